// File: doc/BRIEF.md
# Registered Four-Bit Arithmetic Logic Unit

This block is a small clocked arithmetic logic unit. It takes two operands, a carry input, a unit-select bit and a two-bit operation select. A single clock edge captures all of them together in an input register bank. The combinational core has two parts. The arithmetic path first conditions the operands and then feeds them to a carry-lookahead adder. The logic path applies bitwise operators. A second clock edge captures the chosen result and the carry output in an output register bank. A result therefore appears on the clock edge after the edge that captured its operands.

The arithmetic path always computes X + Y + carry_in. The operation select decides what X and Y are, so one adder gives eight operations: sum, incremented sum, sum with inverted B, difference, transfer A, increment A, decrement B and transfer B. The logic path gives four operations: exclusive OR, AND, OR and inversion of A.

Top module: `alu4_reg`

## Requirements
- R1: The block captures op_a, op_b, carry_in, mode_logic and sel on a rising clock edge. It presents the matching result and carry_out from the next rising edge onward, so a result is visible two edges after its inputs are driven.
- R2: With mode_logic=0 and sel=2'b00, {carry_out,result} equals op_a + op_b + carry_in, computed W+1 bits wide.
- R3: With mode_logic=0 and sel=2'b01, {carry_out,result} equals op_a + ~op_b + carry_in. With carry_in=1 this is op_a - op_b, and carry_out is 1 exactly when op_a >= op_b, unsigned.
- R4: With mode_logic=0 and sel=2'b10, {carry_out,result} equals op_a + carry_in. This gives transfer A when carry_in=0 and A+1 when carry_in=1. carry_out is 1 only when op_a is all ones and carry_in=1.
- R5: With mode_logic=0 and sel=2'b11, {carry_out,result} equals (all ones) + op_b + carry_in. This gives B-1 with carry_out=(op_b!=0) when carry_in=0, and transfer B with carry_out=1 when carry_in=1.
- R6: With mode_logic=1, sel values 2'b00, 2'b01, 2'b10 and 2'b11 give op_a XOR op_b, op_a AND op_b, op_a OR op_b and NOT op_a respectively. carry_out is 0.
- R7: With mode_logic=1, carry_in has no effect on result or carry_out.
- R8: A synchronous active-high rst clears both register banks. result and carry_out read 0 after a reset edge, and the first edge after rst falls outputs the all-zero input bank, which gives result 0 and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of both register banks |
| op_a | input | W | Operand A |
| op_b | input | W | Operand B |
| carry_in | input | 1 | Carry into the adder |
| mode_logic | input | 1 | 1 selects the logic unit, 0 the arithmetic unit |
| sel | input | 2 | Operation select within the chosen unit |
| result | output | W | Registered result |
| carry_out | output | 1 | Registered carry out of the top adder bit, 0 in logic mode |

## Verification
The clearing of the input bank is the hardest behaviour to see from the ports. It shows only in the one result produced on the first edge after reset is released, and only if the operand pins already hold non-zero values during reset. The stimulus therefore holds a non-zero operand pair during reset, checks for a zero output on that first edge, and then checks the sum on the next edge. Carry corner cases also need care: decrement of zero, increment of all ones, and borrow on equal operands. The stimulus reaches them by streaming every operand pair against every mode, select and carry-in combination back to back, so each input register sees a new value on every cycle.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  // Operation select codes, shared by both units
  typedef enum logic [1:0] {
    SEL_00 = 2'b00,  // arith: A+B(+c)   logic: XOR
    SEL_01 = 2'b01,  // arith: A+~B(+c)  logic: AND
    SEL_10 = 2'b10,  // arith: A(+c)     logic: OR
    SEL_11 = 2'b11   // arith: ~0+B(+c)  logic: NOT A
  } sel_e;

  typedef struct packed {
    logic       mode_logic;
    logic [1:0] sel;
    logic       cin;
  } ctl_t;
endpackage

// File: rtl/alu4_opcond.sv
module alu4_opcond #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] x,
  output logic [W-1:0] y
);
  import alu4_pkg::*;

  always_comb begin
    x = a;
    y = b;
    case (sel_e'(sel))
      SEL_00: y = b;
      SEL_01: y = ~b;
      SEL_10: y = '0;
      SEL_11: begin
        x = '1;
        y = b;
      end
      default: y = b;
    endcase
  end
endmodule

// File: rtl/alu4_cla.sv
module alu4_cla #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] prop;
  logic [W-1:0] gen;
  logic [W:0]   carry;

  genvar k;
  generate
    for (k = 0; k < W; k++) begin : g_pg
      assign prop[k] = x[k] ^ y[k];
      assign gen[k]  = x[k] & y[k];
    end
  endgenerate

  // Flat lookahead: each carry is a sum of products over generate/propagate
  always_comb begin
    logic acc;
    logic chain;
    carry[0] = cin;
    for (int i = 0; i < W; i++) begin
      acc   = gen[i];
      chain = prop[i];
      for (int j = i - 1; j >= 0; j--) begin
        acc   = acc | (chain & gen[j]);
        chain = chain & prop[j];
      end
      carry[i+1] = acc | (chain & cin);
    end
  end

  assign sum  = prop ^ carry[W-1:0];
  assign cout = carry[W];
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] f
);
  import alu4_pkg::*;

  always_comb begin
    case (sel_e'(sel))
      SEL_00:  f = a ^ b;
      SEL_01:  f = a & b;
      SEL_10:  f = a | b;
      SEL_11:  f = ~a;
      default: f = ~a;
    endcase
  end
endmodule

// File: rtl/alu4_reg.sv
module alu4_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  input  logic         mode_logic,
  input  logic [1:0]   sel,
  output logic [W-1:0] result,
  output logic         carry_out
);
  import alu4_pkg::*;

  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  ctl_t         ctl_q;

  // Input bank
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      ctl_q <= '0;
    end else begin
      a_q   <= op_a;
      b_q   <= op_b;
      ctl_q <= '{mode_logic: mode_logic, sel: sel, cin: carry_in};
    end
  end

  logic [W-1:0] x_c;
  logic [W-1:0] y_c;
  logic [W-1:0] arith_f;
  logic         arith_co;
  logic [W-1:0] logic_f;

  alu4_opcond #(.W(W)) u_cond (
    .a(a_q), .b(b_q), .sel(ctl_q.sel), .x(x_c), .y(y_c)
  );

  alu4_cla #(.W(W)) u_cla (
    .x(x_c), .y(y_c), .cin(ctl_q.cin), .sum(arith_f), .cout(arith_co)
  );

  alu4_logic #(.W(W)) u_lu (
    .a(a_q), .b(b_q), .sel(ctl_q.sel), .f(logic_f)
  );

  // Output bank
  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else if (ctl_q.mode_logic) begin
      result    <= logic_f;
      carry_out <= 1'b0;
    end else begin
      result    <= arith_f;
      carry_out <= arith_co;
    end
  end
endmodule

// File: rtl/alu4_reg_chk.sv
module alu4_reg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         carry_in,
  input logic         mode_logic,
  input logic [1:0]   sel,
  input logic [W-1:0] result,
  input logic         carry_out
);
  logic [1:0] warm_cnt;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) warm_cnt <= '0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end

  wire warm = (warm_cnt == 2'd2);

  a_r2_add_sum: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(mode_logic, 2) && $past(sel, 2) == 2'b00)
    |-> ({carry_out, result} == ({1'b0, $past(op_a, 2)} + {1'b0, $past(op_b, 2)}
                                 + {{W{1'b0}}, $past(carry_in, 2)})));

  a_r3_sub_carry: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(mode_logic, 2) && $past(sel, 2) == 2'b01 && $past(carry_in, 2))
    |-> (carry_out == ($past(op_a, 2) >= $past(op_b, 2))));

  a_r4_pass_a: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(mode_logic, 2) && $past(sel, 2) == 2'b10 && !$past(carry_in, 2))
    |-> (result == $past(op_a, 2) && !carry_out));

  a_r5_pass_b: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(mode_logic, 2) && $past(sel, 2) == 2'b11 && $past(carry_in, 2))
    |-> (result == $past(op_b, 2) && carry_out));

  a_r6_logic_nocarry: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(mode_logic, 2)) |-> !carry_out);

  a_r6_not_a: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(mode_logic, 2) && $past(sel, 2) == 2'b11)
    |-> (result == ~$past(op_a, 2)));

  // R8: outputs read zero after a reset edge
  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      a_r8_reset_clear: assert (result == '0 && carry_out == 1'b0);
    end
  end
endmodule

bind alu4_reg alu4_reg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .mode_logic(mode_logic), .sel(sel), .result(result), .carry_out(carry_out)
);

// File: tb/alu4_reg_bench.sv
module alu4_reg_bench;
  localparam int W          = 4;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 1 << (2 * W + 4);

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         carry_in;
  logic         mode_logic;
  logic [1:0]   sel;
  logic [W-1:0] result;
  logic         carry_out;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alu4_reg #(.W(W)) u_alu4_reg (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .mode_logic(mode_logic), .sel(sel), .result(result), .carry_out(carry_out)
  );

  function automatic logic [W:0] model(input logic ml, input logic [1:0] s,
                                       input logic c, input logic [W-1:0] a,
                                       input logic [W-1:0] b);
    int unsigned mask = (1 << W) - 1;
    int unsigned r;
    if (ml) begin
      case (s)
        2'b00:   r = a ^ b;
        2'b01:   r = a & b;
        2'b10:   r = a | b;
        default: r = ~a & mask;
      endcase
      r = r & mask;
    end else begin
      case (s)
        2'b00:   r = a + b + c;
        2'b01:   r = a + (mask - b) + c;
        2'b10:   r = a + c;
        default: r = mask + b + c;
      endcase
    end
    return r[W:0];
  endfunction

  function automatic string tag_of(input logic ml, input logic [1:0] s, input logic c);
    if (ml) return c ? "R7" : "R6";
    case (s)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {carry_out,result} actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    logic [W:0] exp1, exp2;
    string      tag1, tag2;
    exp1 = '0; exp2 = '0; tag1 = ""; tag2 = "";
    rst = 1'b1; op_a = 4'd9; op_b = 4'd5; carry_in = 1'b0;
    mode_logic = 1'b0; sel = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset output", {carry_out, result}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 input bank cleared", {carry_out, result}, '0);
    @(negedge clk);
    check("R1 first captured result", {carry_out, result}, model(0, 2'b00, 0, 4'd9, 4'd5));

    for (int n = 0; n < NVEC + 2; n++) begin
      if (n >= 2) check(tag2, {carry_out, result}, exp2);
      exp2 = exp1;
      tag2 = tag1;
      if (n < NVEC) begin
        op_b       = n[W-1:0];
        op_a       = n[2*W-1:W];
        carry_in   = n[2*W];
        sel        = n[2*W+2:2*W+1];
        mode_logic = n[2*W+3];
        exp1 = model(mode_logic, sel, carry_in, op_a, op_b);
        tag1 = tag_of(mode_logic, sel, carry_in);
      end
      @(negedge clk);
    end

    // reset in mid-stream clears outputs
    op_a = 4'hF; op_b = 4'h1; mode_logic = 1'b0; sel = 2'b00; carry_in = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 mid-stream reset", {carry_out, result}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 bank cleared again", {carry_out, result}, '0);
    @(negedge clk);
    check("R1 after reset", {carry_out, result}, model(0, 2'b00, 1, 4'hF, 4'h1));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule